// File: doc/BRIEF.md
# Bit-Plane Counter Debouncer

This block cleans up a word of mechanical contact inputs. Every input owns a two-bit saturating-free counter, but the counters are not kept as separate little registers: all low bits live together in one plane word and all high bits in another, so one set of bitwise operations advances every counter at the same moment. The block only acts on a sample strobe, which the surrounding logic pulses at the bounce-filter rate (typically every 10 to 20 ms).

A raw input that differs from its filtered level counts upward by one on each strobe. If it ever agrees with the filtered level on a strobe, its counter is wiped to zero. When a counter wraps from its top value back to zero while the disagreement persists, the new level is taken, the filtered bit is inverted and the matching bit of a change word is raised for that one sample interval. Downstream logic may follow the filtered level directly or act on the change word to build toggle or momentary behaviour.

Raw inputs are first passed through a two-flop synchroniser, and the asynchronous reset is released through its own two-flop chain.

Top module: `vdb_debouncer`

## Requirements
- R1: While reset is asserted and after it is released, the filtered state word and the change word are all zeros.
- R2: Between sample strobes (strobe low) neither the filtered state nor the change word alters, whatever the raw inputs do.
- R3: An input whose synchronised level differs from its filtered level on four consecutive strobes has its filtered bit inverted by the fourth strobe, and not by the third.
- R4: A strobe on which an input agrees with its filtered level clears that input's count, so a run of disagreement broken by one agreeing strobe must start again from four.
- R5: Bit i of the change word is 1 for exactly the sample interval following the strobe that flipped filtered bit i, and returns to 0 on the next strobe unless that strobe flips the bit again.
- R6: All inputs are filtered independently and in parallel; several filtered bits may flip on the same strobe, and an input never flips while it agrees with its filtered level.
- R7: Acceptance works in both directions, 0 to 1 and 1 to 0, with the same four-strobe count.
- R8: Raw inputs pass through two synchronising flops; a raw change presented one clock before a strobe is not yet seen by that strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | One-clock strobe that advances the filter |
| raw_in | input | WIDTH (8) | Unsynchronised contact inputs |
| level_out | output | WIDTH (8) | Filtered state word |
| flip_out | output | WIDTH (8) | Bits whose filtered state flipped on the last strobe |

## Verification
The interesting coincidence is one input completing its fourth disagreeing strobe, and so being accepted, on the very strobe where a neighbouring input bounces back and has its count wiped. The bench provokes it by aligning the inputs so one bit reaches its wrap while another returns to agreement on that strobe, then judges that only the first bit appears in the change word and that the second needs a full fresh run of four before it flips. A second overlap, several bits wrapping together, is judged by a multi-bit change word on a single strobe.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
  // default number of debounced inputs
  localparam int unsigned VDB_WIDTH_DEF = 8;
  // default depth of the input and reset synchronisers
  localparam int unsigned VDB_SYNC_DEF  = 2;
  // counter phases as {high plane, low plane}
  typedef enum logic [1:0] {
    CNT_IDLE  = 2'b00,
    CNT_ONE   = 2'b01,
    CNT_TWO   = 2'b10,
    CNT_THREE = 2'b11
  } vdb_cnt_e;
endpackage

// File: rtl/vdb_rst_sync.sv
module vdb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/vdb_sync.sv
module vdb_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = d_in;
    end else begin : g_next
      always_comb stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/vdb_planes.sv
module vdb_planes #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] hi_q,
  output logic [WIDTH-1:0] lo_q,
  output logic [WIDTH-1:0] roll
);
  import vdb_pkg::*;

  logic [WIDTH-1:0] hi_d;
  logic [WIDTH-1:0] lo_d;

  // per-input advance then clear; a pending bit whose count lands on idle has wrapped
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] adv;
    logic [1:0] kept;
    always_comb begin
      adv[1]  = hi_q[i] ^ lo_q[i];
      adv[0]  = ~lo_q[i];
      kept    = adv & {2{pend[i]}};
      hi_d[i] = kept[1];
      lo_d[i] = kept[0];
      roll[i] = pend[i] & (vdb_cnt_e'(kept) == CNT_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (tick) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R4: an input that agreed on the last strobe holds a zero count
  assert_agree_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (((hi_q | lo_q) & ~$past(pend)) == '0));

  // R2: planes do not move without a strobe
  assert_planes_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/vdb_accept.sv
module vdb_accept #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] raw_sync,
  input  logic [WIDTH-1:0] roll,
  output logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] state_q,
  output logic [WIDTH-1:0] flip_q
);
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] flip_d;

  always_comb begin
    pend    = raw_sync ^ state_q;
    state_d = state_q ^ roll;
    flip_d  = roll;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      flip_q  <= '0;
    end else if (tick) begin
      state_q <= state_d;
      flip_q  <= flip_d;
    end
  end

  // R2: outputs frozen between strobes
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(state_q) && $stable(flip_q)));

  // R3: a flipped bit takes the level the input showed on that strobe
  assert_flip_takes_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((flip_q & (state_q ^ $past(raw_sync))) == '0));

  // R6: no flip on an input that agreed
  assert_no_flip_on_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((flip_q & ~$past(pend)) == '0));
endmodule

// File: rtl/vdb_debouncer.sv
module vdb_debouncer #(
  parameter int unsigned WIDTH = vdb_pkg::VDB_WIDTH_DEF,
  parameter int unsigned SYNC  = vdb_pkg::VDB_SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] level_out,
  output logic [WIDTH-1:0] flip_out
);
  logic             rst_int_n;
  logic [WIDTH-1:0] raw_sync;
  logic [WIDTH-1:0] pend;
  logic [WIDTH-1:0] roll;
  logic [WIDTH-1:0] hi_q;
  logic [WIDTH-1:0] lo_q;

  vdb_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vdb_sync #(.WIDTH(WIDTH), .STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  (raw_in),
    .q_out (raw_sync)
  );

  vdb_planes #(.WIDTH(WIDTH)) u_planes (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (sample_tick),
    .pend  (pend),
    .hi_q  (hi_q),
    .lo_q  (lo_q),
    .roll  (roll)
  );

  vdb_accept #(.WIDTH(WIDTH)) u_accept (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (sample_tick),
    .raw_sync (raw_sync),
    .roll     (roll),
    .pend     (pend),
    .state_q  (level_out),
    .flip_q   (flip_out)
  );

  // R5: a flip leaves the count of that input at zero
  assert_flip_resets_count_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_tick |=> (((hi_q | lo_q) & flip_out) == '0));
endmodule

// File: tb/vdb_debouncer_tb.sv
module vdb_debouncer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sample_tick;
  logic [W-1:0] raw_in;
  logic [W-1:0] level_out;
  logic [W-1:0] flip_out;

  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;

  logic [W-1:0] exp_state;
  logic [W-1:0] exp_flip;
  int           exp_cnt [W];

  always #4 clk = ~clk;

  vdb_debouncer #(.WIDTH(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .raw_in      (raw_in),
    .level_out   (level_out),
    .flip_out    (flip_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // requirement model: consecutive disagreeing strobes, accepted on the fourth
  task automatic model_tick(input logic [W-1:0] seen);
    exp_flip = '0;
    for (int i = 0; i < W; i++) begin
      if (seen[i] != exp_state[i]) begin
        exp_cnt[i]++;
        if (exp_cnt[i] == 4) begin
          exp_state[i] = ~exp_state[i];
          exp_flip[i]  = 1'b1;
          exp_cnt[i]   = 0;
        end
      end else begin
        exp_cnt[i] = 0;
      end
    end
  endtask

  task automatic set_raw(input logic [W-1:0] v);
    @(negedge clk);
    raw_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input string req);
    @(negedge clk);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    model_tick(raw_in);
    chk(req, level_out, exp_state);
    chk(req, flip_out, exp_flip);
  endtask

  task automatic t_reset;
    rst_n = 1'b1; sample_tick = 1'b0; raw_in = '0;
    exp_state = '0; exp_flip = '0;
    for (int i = 0; i < W; i++) exp_cnt[i] = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset state", level_out, '0);
    chk("R1 in reset flips", flip_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release state", level_out, '0);
    chk("R1 after release flips", flip_out, '0);
  endtask

  task automatic t_no_tick;
    set_raw(8'hFF);
    repeat (20) @(negedge clk);
    chk("R2 no strobe state", level_out, '0);
    chk("R2 no strobe flips", flip_out, '0);
    set_raw(8'h00);
  endtask

  task automatic t_four;
    set_raw(8'h01);
    pulse("R3 run 1");
    pulse("R3 run 2");
    pulse("R3 run 3");
    chk("R3 not after three", level_out, 8'h00);
    pulse("R3 run 4");
    chk("R3 flips on fourth", level_out, 8'h01);
    chk("R5 flip marked", flip_out, 8'h01);
    pulse("R5 flip cleared next strobe");
    chk("R5 flip word back to zero", flip_out, 8'h00);
  endtask

  task automatic t_bounce;
    // bit1 disagrees twice, bounces back, then needs four fresh strobes
    set_raw(8'h03);
    pulse("R4 a"); pulse("R4 b");
    set_raw(8'h01);
    pulse("R4 bounce back");
    set_raw(8'h03);
    pulse("R4 c"); pulse("R4 d"); pulse("R4 e");
    chk("R4 restarted count not yet done", level_out, 8'h01);
    pulse("R4 f");
    chk("R4 accepted after fresh four", level_out, 8'h03);
  endtask

  task automatic t_overlap;
    // bit2 reaches its fourth strobe while bit3 bounces back that same strobe
    set_raw(8'h0F);
    pulse("R6 o1"); pulse("R6 o2"); pulse("R6 o3");
    set_raw(8'h07);
    pulse("R6 o4");
    chk("R6 only wrapped bit flips", flip_out, 8'h04);
    set_raw(8'h0F);
    pulse("R6 p1"); pulse("R6 p2"); pulse("R6 p3");
    chk("R6 bounced bit still pending", level_out, 8'h07);
    pulse("R6 p4");
    chk("R6 bounced bit accepted later", flip_out, 8'h08);
    // several bits together
    set_raw(8'hFF);
    pulse("R6 m1"); pulse("R6 m2"); pulse("R6 m3"); pulse("R6 m4");
    chk("R6 multi-bit flip", flip_out, 8'hF0);
  endtask

  task automatic t_fall;
    set_raw(8'h5A);
    pulse("R7 f1"); pulse("R7 f2"); pulse("R7 f3");
    chk("R7 falling held after three", level_out, 8'hFF);
    pulse("R7 f4");
    chk("R7 falling accepted", level_out, 8'h5A);
    chk("R7 falling flips", flip_out, 8'hA5);
  endtask

  task automatic t_sync;
    logic [W-1:0] old;
    old = raw_in;
    @(negedge clk);
    raw_in = 8'h5B;
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    model_tick(old);
    chk("R8 late change unseen", level_out, exp_state);
    repeat (3) @(negedge clk);
    pulse("R8 s1"); pulse("R8 s2"); pulse("R8 s3");
    chk("R8 not after late strobe plus three", level_out, 8'h5A);
    pulse("R8 s4");
    chk("R8 accepted after four seen", level_out, 8'h5B);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_no_tick;
    t_four;
    t_bounce;
    t_overlap;
    t_fall;
    t_sync;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule